// File: doc/BRIEF.md
# Plucked-String Loop Synthesis Datapath

This block turns a stream of signed 8-bit audio samples into the output of an extended plucked-string model. It runs in fixed point at audio rate, one sample per input strobe. Each accepted sample first goes through a one-pole pick-direction lowpass and then a pick-position comb. The result enters a recirculating loop. In the loop, a delay line feeds a two-zero string-damping filter and a second one-pole lowpass, and these close back on a saturating adder. After the loop, a one-pole level lowpass produces the output sample. A later gain and clipping stage would take that output.

Processing is split into three sample stages: the input filters, the loop, and the output filter. Each stage holds a different sample, so the output for input k appears on the strobe of input k+2. Both histories (the comb taps and the loop delay) live in on-chip synchronous RAMs. After reset, a sweep writes zero to every location of both RAMs before any sample is taken. Delay lengths, filter shifts and damping coefficients come in on configuration ports and are held steady while samples flow.

Top module: `pluck_string_loop`

## Requirements
- R1: After reset is released, `init_done` stays low for at least 2^LAW and at most 2^LAW+4 clock cycles and then rises. While it is low, `out_valid` and `out_sample` stay at zero.
- R2: Stage one computes a[n] = x[n] + ((a[n-1] - x[n]) >>> s) with an arithmetic (floor) shift, where s = `cfg_pick_shift`. When s = 0 the stage passes x[n] unchanged.
- R3: The comb computes b[n] = a[n] - a[n-M], where M = `cfg_comb_dist` (1 to 255). History from before the reset counts as zero.
- R4: The loop output is v[n] = sat(b[n] + f[n]). The damping filter reads the loop's own output from N = `cfg_loop_len` samples back (2 to 1023), so the loop period is exactly N samples.
- R5: The damping filter computes h[n] = (g0·v[n-N-1] + g1·(v[n-N] + v[n-N-2])) >>> 7. Here g0 = `cfg_g0` and g1 = `cfg_g1` are signed Q1.7 values.
- R6: The in-loop lowpass computes f[n] = h[n] + ((f[n-1] - h[n]) >>> `cfg_loop_shift`), with shift 0 giving a pass-through.
- R7: The loop adder saturates to the signed 8-bit range: sums above 127 give 127, and sums below -128 give -128.
- R8: The output filter computes y[n] = v[n] + ((y[n-1] - v[n]) >>> `cfg_level_shift`), with shift 0 giving a pass-through.
- R9: An accepted strobe raises `out_valid` for exactly one cycle, starting one clock after the acceptance edge. The first two accepted strobes after reset produce no `out_valid`. From then on, the pulse for accepted strobe k carries y[k-2].
- R10: `in_valid` is ignored while `init_done` is low and in the clock cycle right after an accepted strobe. A new strobe may be accepted two cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 8 | Signed input sample |
| cfg_loop_len | input | LAW | Loop period N in samples |
| cfg_comb_dist | input | CAW | Comb distance M in samples |
| cfg_pick_shift | input | 3 | Pick lowpass shift |
| cfg_loop_shift | input | 3 | In-loop lowpass shift |
| cfg_level_shift | input | 3 | Output lowpass shift |
| cfg_g0 | input | 8 | Damping centre tap, signed Q1.7 |
| cfg_g1 | input | 8 | Damping outer taps, signed Q1.7 |
| init_done | output | 1 | High once the RAM clear sweep has finished |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 8 | Signed output sample |

## Verification
Two things coincide when strobes arrive at the minimum spacing of two cycles. The next sample is accepted, and its RAM reads issued, on the same edge that ends the previous result's `out_valid` pulse. That same previous result was written into the loop RAM one cycle earlier. The bench feeds every scenario at this spacing, including the shortest loop (N = 2). With N = 2 the loop read lands on the location written two strobes back. Every output is compared with a sample-by-sample model of the filter equations, so a read that picked up stale or not-yet-written data, or an acceptance that was dropped, shows up as a wrong value or a missing pulse.

// File: rtl/pluck_pkg.sv
package pluck_pkg;
  localparam int SMP_W  = 8;            // audio sample width
  localparam int COMB_W = SMP_W + 1;    // comb difference width
  localparam int COEF_W = 8;            // Q1.7 damping coefficients
  localparam int FRAC_W = COEF_W - 1;
  localparam int DAMP_W = 2 * SMP_W + 2; // full damping accumulator
  localparam int FILT_W = DAMP_W - FRAC_W; // loop filter width after scaling
  localparam int SUM_W  = FILT_W + 1;   // loop adder width

  function automatic logic signed [SMP_W-1:0] clip_smp(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] hi;
    logic signed [SUM_W-1:0] lo;
    hi = SUM_W'((1 << (SMP_W - 1)) - 1);
    lo = -SUM_W'(1 << (SMP_W - 1));
    if (v > hi)      clip_smp = hi[SMP_W-1:0];
    else if (v < lo) clip_smp = lo[SMP_W-1:0];
    else             clip_smp = v[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/pluck_ram.sv
module pluck_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pluck_onepole.sv
module pluck_onepole #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y_prev,
  input  logic        [2:0]   shift,
  output logic signed [W-1:0] y
);
  logic signed [W:0] diff;
  logic signed [W:0] step;
  logic signed [W:0] sum;

  always_comb begin
    diff = {y_prev[W-1], y_prev} - {x[W-1], x};
    step = diff >>> shift;
    sum  = {x[W-1], x} + step;
    y    = (shift == 3'd0) ? x : sum[W-1:0];
  end

  // output must lie between the new input and the previous state (R2, R6, R8)
  always_comb begin
    assert_lp_bound_R2: assert ((y >= x && y <= y_prev) || (y <= x && y >= y_prev));
  end
endmodule

// File: rtl/pluck_damp.sv
module pluck_damp
  import pluck_pkg::*;
(
  input  logic signed [SMP_W-1:0]  d_now,
  input  logic signed [SMP_W-1:0]  d_mid,
  input  logic signed [SMP_W-1:0]  d_old,
  input  logic signed [COEF_W-1:0] g_mid,
  input  logic signed [COEF_W-1:0] g_out,
  output logic signed [FILT_W-1:0] h
);
  logic signed [SMP_W:0]          outer;
  logic signed [SMP_W+COEF_W-1:0] p_mid;
  logic signed [SMP_W+COEF_W:0]   p_out;
  logic signed [DAMP_W-1:0]       acc;

  always_comb begin
    outer = {d_now[SMP_W-1], d_now} + {d_old[SMP_W-1], d_old};
    p_mid = g_mid * d_mid;
    p_out = g_out * outer;
    acc   = DAMP_W'(p_mid) + DAMP_W'(p_out);
    h     = acc[DAMP_W-1:FRAC_W];
  end
endmodule

// File: rtl/pluck_string_loop.sv
module pluck_string_loop
  import pluck_pkg::*;
#(
  parameter int CAW = 8,
  parameter int LAW = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [SMP_W-1:0]  in_sample,
  input  logic [LAW-1:0]           cfg_loop_len,
  input  logic [CAW-1:0]           cfg_comb_dist,
  input  logic [2:0]               cfg_pick_shift,
  input  logic [2:0]               cfg_loop_shift,
  input  logic [2:0]               cfg_level_shift,
  input  logic signed [COEF_W-1:0] cfg_g0,
  input  logic signed [COEF_W-1:0] cfg_g1,
  output logic                     init_done,
  output logic                     out_valid,
  output logic signed [SMP_W-1:0]  out_sample
);
  localparam int CLR_W = ((LAW > CAW) ? LAW : CAW) + 1;

  // reset release synchroniser
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  // state
  logic [CLR_W-1:0]         clr_cnt, clr_cnt_d;
  logic                     busy, busy_d;
  logic [1:0]               fill, fill_d;
  logic signed [SMP_W-1:0]  x_q, x_q_d;
  logic signed [SMP_W-1:0]  a_st, a_st_d;
  logic [CAW-1:0]           comb_ptr, comb_ptr_d;
  logic signed [COMB_W-1:0] b_reg, b_reg_d;
  logic signed [SMP_W-1:0]  d1, d1_d, d2, d2_d;
  logic signed [FILT_W-1:0] f_st, f_st_d;
  logic [LAW-1:0]           loop_ptr, loop_ptr_d;
  logic signed [SMP_W-1:0]  v_reg, v_reg_d;
  logic signed [SMP_W-1:0]  y_st, y_st_d;
  logic                     ov, ov_d;

  // datapath wires
  logic                     clearing, accept;
  logic [SMP_W-1:0]         comb_rd, loop_rd;
  logic signed [SMP_W-1:0]  a_new, y_new, v_new;
  logic signed [COMB_W-1:0] b_new;
  logic signed [FILT_W-1:0] h_new, f_new;
  logic signed [SUM_W-1:0]  loop_sum;

  assign clearing  = !clr_cnt[CLR_W-1];
  assign init_done = clr_cnt[CLR_W-1];
  assign accept    = in_valid && init_done && !busy;

  pluck_ram #(.DW(SMP_W), .AW(CAW)) u_comb_ram (
    .clk(clk), .we(clearing || busy),
    .waddr(clearing ? clr_cnt[CAW-1:0] : comb_ptr),
    .wdata(clearing ? '0 : a_new),
    .re(accept), .raddr(comb_ptr - cfg_comb_dist), .rdata(comb_rd)
  );

  pluck_ram #(.DW(SMP_W), .AW(LAW)) u_loop_ram (
    .clk(clk), .we(clearing || busy),
    .waddr(clearing ? clr_cnt[LAW-1:0] : loop_ptr),
    .wdata(clearing ? '0 : v_new),
    .re(accept), .raddr(loop_ptr - cfg_loop_len), .rdata(loop_rd)
  );

  // stage A: pick-direction lowpass, then comb
  pluck_onepole #(.W(SMP_W)) u_pick (
    .x(x_q), .y_prev(a_st), .shift(cfg_pick_shift), .y(a_new)
  );
  assign b_new = {a_new[SMP_W-1], a_new} - {comb_rd[SMP_W-1], comb_rd};

  // stage B: damping, loop lowpass, saturating adder
  pluck_damp u_damp (
    .d_now(loop_rd), .d_mid(d1), .d_old(d2), .g_mid(cfg_g0), .g_out(cfg_g1), .h(h_new)
  );
  pluck_onepole #(.W(FILT_W)) u_loop_lp (
    .x(h_new), .y_prev(f_st), .shift(cfg_loop_shift), .y(f_new)
  );
  assign loop_sum = SUM_W'(b_reg) + SUM_W'(f_new);
  assign v_new    = clip_smp(loop_sum);

  // stage C: level lowpass
  pluck_onepole #(.W(SMP_W)) u_level (
    .x(v_reg), .y_prev(y_st), .shift(cfg_level_shift), .y(y_new)
  );

  // next state
  always_comb begin
    clr_cnt_d  = clearing ? clr_cnt + 1'b1 : clr_cnt;
    busy_d     = accept;
    fill_d     = fill;
    x_q_d      = accept ? in_sample : x_q;
    a_st_d     = a_st;
    comb_ptr_d = comb_ptr;
    b_reg_d    = b_reg;
    d1_d       = d1;
    d2_d       = d2;
    f_st_d     = f_st;
    loop_ptr_d = loop_ptr;
    v_reg_d    = v_reg;
    y_st_d     = y_st;
    ov_d       = 1'b0;
    if (busy) begin
      a_st_d     = a_new;
      comb_ptr_d = comb_ptr + 1'b1;
      b_reg_d    = b_new;
      d1_d       = loop_rd;
      d2_d       = d1;
      f_st_d     = f_new;
      loop_ptr_d = loop_ptr + 1'b1;
      v_reg_d    = v_new;
      y_st_d     = y_new;
      ov_d       = (fill == 2'd2);
      fill_d     = (fill == 2'd2) ? fill : fill + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      clr_cnt  <= '0;
      busy     <= 1'b0;
      fill     <= '0;
      x_q      <= '0;
      a_st     <= '0;
      comb_ptr <= '0;
      b_reg    <= '0;
      d1       <= '0;
      d2       <= '0;
      f_st     <= '0;
      loop_ptr <= '0;
      v_reg    <= '0;
      y_st     <= '0;
      ov       <= 1'b0;
    end else begin
      clr_cnt  <= clr_cnt_d;
      busy     <= busy_d;
      fill     <= fill_d;
      x_q      <= x_q_d;
      a_st     <= a_st_d;
      comb_ptr <= comb_ptr_d;
      b_reg    <= b_reg_d;
      d1       <= d1_d;
      d2       <= d2_d;
      f_st     <= f_st_d;
      loop_ptr <= loop_ptr_d;
      v_reg    <= v_reg_d;
      y_st     <= y_st_d;
      ov       <= ov_d;
    end
  end

  assign out_valid  = ov;
  assign out_sample = y_st;

  assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !init_done |-> (!out_valid && !busy));
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> (comb_ptr == CAW'($past(comb_ptr) + 1'b1)));
  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |=> !out_valid);
  assert_one_busy_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> !busy);
  assert_loop_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |=> $stable(loop_ptr));
endmodule

// File: tb/pluck_string_loop_test.sv
module pluck_string_loop_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAW = 10;
  localparam int CAW = 8;
  localparam int WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [7:0] in_sample;
  logic [LAW-1:0]    cfg_loop_len;
  logic [CAW-1:0]    cfg_comb_dist;
  logic [2:0]        cfg_pick_shift, cfg_loop_shift, cfg_level_shift;
  logic signed [7:0] cfg_g0, cfg_g1;
  logic              init_done, out_valid;
  logic signed [7:0] out_sample;

  int checks = 0;
  int fails  = 0;

  // model state
  int ah [4096];
  int vh [4096];
  int ym [4096];
  int ma, mf, my, ns;

  always #(CLK_PERIOD/2) clk = ~clk;

  pluck_string_loop #(.CAW(CAW), .LAW(LAW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_loop_len(cfg_loop_len), .cfg_comb_dist(cfg_comb_dist),
    .cfg_pick_shift(cfg_pick_shift), .cfg_loop_shift(cfg_loop_shift),
    .cfg_level_shift(cfg_level_shift), .cfg_g0(cfg_g0), .cfg_g1(cfg_g1),
    .init_done(init_done), .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int x, input int prev, input int s);
    return (s == 0) ? x : x + ((prev - x) >>> s);
  endfunction

  function automatic int hist(input bit is_v, input int idx);
    if (idx < 0) return 0;
    return is_v ? vh[idx] : ah[idx];
  endfunction

  task automatic model_step(input int x);
    int a, b, h, f, v, y, n, m;
    n = int'(cfg_loop_len);
    m = int'(cfg_comb_dist);
    a = pick(x, ma, int'(cfg_pick_shift));
    ah[ns] = a;
    b = a - hist(1'b0, ns - m);
    h = (int'(cfg_g0) * hist(1'b1, ns - n - 1)
         + int'(cfg_g1) * (hist(1'b1, ns - n) + hist(1'b1, ns - n - 2))) >>> 7;
    f = pick(h, mf, int'(cfg_loop_shift));
    v = b + f;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    vh[ns] = v;
    y = pick(v, my, int'(cfg_level_shift));
    ym[ns] = y;
    ma = a; mf = f; my = y;
    ns++;
  endtask

  task automatic setup(input int n, input int m, input int ps, input int ls,
                       input int os, input int g0, input int g1);
    cfg_loop_len    = LAW'(n);
    cfg_comb_dist   = CAW'(m);
    cfg_pick_shift  = 3'(ps);
    cfg_loop_shift  = 3'(ls);
    cfg_level_shift = 3'(os);
    cfg_g0          = 8'(g0);
    cfg_g1          = 8'(g1);
  endtask

  task automatic do_reset();
    in_valid  = 1'b0;
    in_sample = '0;
    rst_n     = 1'b0;
    ma = 0; mf = 0; my = 0; ns = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!init_done) @(negedge clk);
  endtask

  // one accepted strobe, optionally held for a second (ignored) cycle
  task automatic send(input int x, input bit hold, input int x2, input string req);
    int k;
    in_valid  = 1'b1;
    in_sample = 8'(x);
    @(posedge clk);
    @(negedge clk);
    if (hold) in_sample = 8'(x2);
    else      in_valid  = 1'b0;
    model_step(x);
    k = ns - 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == (k >= 2), {req, " R9 out_valid"}, int'(out_valid), int'(k >= 2));
    if (k >= 2)
      chk(int'(out_sample) == ym[k-2], req, int'(out_sample), ym[k-2]);
  endtask

  task automatic t_reset();
    int cyc;
    setup(8, 4, 0, 0, 0, 0, 0);
    in_valid  = 1'b0;
    in_sample = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(out_sample == 8'sd0, "R1 out_sample in reset", int'(out_sample), 0);
    rst_n = 1'b1;
    ma = 0; mf = 0; my = 0; ns = 0;
    cyc = 0;
    while (!init_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 200) begin
        in_valid  = 1'b1;            // R10: ignored while clearing
        in_sample = 8'sd99;
      end
      if (cyc == 202) in_valid = 1'b0;
      if (!init_done && (out_valid || out_sample != 8'sd0))
        chk(1'b0, "R1 quiet during clear", int'(out_sample), 0);
    end
    chk(cyc >= (1 << LAW) && cyc <= (1 << LAW) + 4, "R1 clear length", cyc, 1 << LAW);
    for (int i = 0; i < 6; i++) send(i * 10 - 20, 1'b0, 0, "R10 after ignored init strobe");
  endtask

  task automatic t_pick();
    setup(300, 200, 2, 0, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 12; i++) send((i < 6) ? 100 : -90, 1'b0, 0, "R2 pick lowpass");
    setup(300, 200, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) send(i * 7 - 11, 1'b0, 0, "R2 shift zero");
  endtask

  task automatic t_comb();
    setup(300, 3, 0, 0, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 14; i++) send((i * 23) % 61 - 30, 1'b0, 0, "R3 comb");
  endtask

  task automatic t_loop();
    setup(5, 255, 0, 1, 0, 64, 32);
    do_reset();
    send(100, 1'b0, 0, "R4 impulse");
    for (int i = 0; i < 30; i++) send(0, 1'b0, 0, "R5 R6 loop decay");
    setup(7, 255, 1, 0, 0, -96, 48);
    do_reset();
    for (int i = 0; i < 30; i++) send((i % 9 == 0) ? -80 : 0, 1'b0, 0, "R5 negative taps");
  endtask

  task automatic t_sat();
    setup(2, 255, 0, 0, 0, 127, 64);
    do_reset();
    for (int i = 0; i < 12; i++) send(120, 1'b0, 0, "R7 high clip");
    for (int i = 0; i < 12; i++) send(-128, 1'b0, 0, "R7 low clip");
  endtask

  task automatic t_level();
    setup(9, 255, 0, 2, 3, 80, 20);
    do_reset();
    for (int i = 0; i < 20; i++) send((i < 10) ? 90 : -60, 1'b0, 0, "R8 level lowpass");
  endtask

  task automatic t_hold();
    setup(4, 2, 1, 0, 1, 64, 0);
    do_reset();
    for (int i = 0; i < 10; i++) send(i * 11 - 40, 1'b1, 127, "R10 held strobe");
  endtask

  task automatic t_long();
    setup(1023, 255, 0, 0, 0, 96, 16);
    do_reset();
    send(80, 1'b0, 0, "R4 long loop");
    for (int i = 0; i < 1040; i++) send((i == 300) ? -50 : 0, 1'b0, 0, "R3 R4 max lengths");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pick();
    t_comb();
    t_loop();
    t_sat();
    t_level();
    t_hold();
    t_long();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule